// File: doc/BRIEF.md
# Widening Vector Add/Subtract Unit

This block is a 128-bit SIMD datapath for a vector execution pipe. It takes two source vectors, A and B, splits them into elements of a chosen width, pairs elements of A with elements of B, extends each element to twice its width and then adds or subtracts. Each destination element is therefore double the width of the source elements, so a result vector holds half as many elements as a source vector. A doubleword operation yields one full 128-bit sum or difference.

Three pairing schemes are available. Cross pairing combines an odd-numbered element of A with the even-numbered element of B just below it. The other two schemes take the even-numbered elements of both sources or the odd-numbered elements of both sources. Operands can be extended as signed, as unsigned, or in a mixed way where A is zero-extended and B is sign-extended. The issuing stage presents the operands and control fields together with a valid strobe. The registered result comes back one clock later with its own valid.

Top module: `simd_widen_addsub`

## Requirements
- R1: With pair_mode = 0 (cross pairing), destination element i is computed from A element 2i+1 and B element 2i. Source element k occupies bits [k*S +: S], where S is the source element width.
- R2: With pair_mode = 1, destination element i uses element 2i of both A and B. With pair_mode = 2, it uses element 2i+1 of both.
- R3: src_width selects the source element width: 0 is 8 bits (8 results of 16 bits), 1 is 16 bits (4 results of 32 bits), 2 is 32 bits (2 results of 64 bits) and 3 is 64 bits (1 result of 128 bits). Destination element i occupies bits [i*2S +: 2S].
- R4: With sign_mode = 0, both operands are sign-extended to the destination width before the operation.
- R5: With sign_mode = 1, both operands are zero-extended to the destination width before the operation.
- R6: With sub_op = 1, the result is extended A minus extended B. With sub_op = 0, it is their sum.
- R7: With sign_mode = 2, A is zero-extended and B is sign-extended. This holds for addition and for subtraction.
- R8: Each result is reduced modulo 2 to the power of the destination width, with no saturation and no flag.
- R9: When in_valid is high at a rising clock edge, res_data shows that operation's result after that edge and res_valid is high for exactly that one cycle. When in_valid is low at an edge, res_valid is low after it.
- R10: When in_valid is low at an edge, res_data keeps its previous value, whatever the other inputs do.
- R11: While rst_n is low, res_valid and res_data are cleared to zero.
- R12: pair_mode = 3 behaves as pair_mode = 1. sign_mode = 3 behaves as sign_mode = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; inputs are captured when it is high |
| pair_mode | input | 2 | 0 cross pairing, 1 even, 2 odd, 3 even |
| sub_op | input | 1 | 0 add, 1 subtract (A minus B) |
| sign_mode | input | 2 | 0 signed, 1 unsigned, 2 A unsigned with B signed, 3 unsigned |
| src_width | input | 2 | Source element width: 0 byte, 1 half, 2 word, 3 doubleword |
| src_a | input | 128 | Source vector A |
| src_b | input | 128 | Source vector B |
| res_valid | output | 1 | Result valid, one cycle after in_valid |
| res_data | output | 128 | Widened result vector |

## Verification
The hardest effects to expose are extension faults. A wrong sign or zero fill only shows when the top bit of the selected element is set, and it is hidden whenever the opposite element is the one that carries that bit. The stimulus therefore uses sources where the elements that get paired hold boundary values, such as 0x80, 0x8000, 0xFFFFFFFF and 2 to the power of 63. Their neighbours hold small distinct indices. Each case is repeated under the signed, unsigned and mixed settings, so a wrong element pick or a wrong fill changes the expected word. The doubleword cases push the sum past 64 bits, so the upper half of the 128-bit result has to carry the extension.

// File: rtl/simd_widen_pkg.sv
package simd_widen_pkg;
  localparam int NUM_WIDTHS = 4;
  localparam int BASE_W     = 8;

  typedef enum logic [1:0] {
    PAIR_CROSS = 2'd0,
    PAIR_EVEN  = 2'd1,
    PAIR_ODD   = 2'd2,
    PAIR_RSVD  = 2'd3
  } pair_e;

  typedef enum logic [1:0] {
    EXT_SIGNED = 2'd0,
    EXT_UNSIGN = 2'd1,
    EXT_MIXED  = 2'd2,
    EXT_RSVD   = 2'd3
  } ext_e;

  typedef struct packed {
    logic a_odd;
    logic b_odd;
    logic a_sgn;
    logic b_sgn;
    logic sub;
  } lane_ctl_t;
endpackage

// File: rtl/wadd_lane.sv
module wadd_lane #(
  parameter int SRC_W = 8,
  localparam int DST_W = 2 * SRC_W
) (
  input  logic [SRC_W-1:0] a_elem,
  input  logic [SRC_W-1:0] b_elem,
  input  logic             a_sgn,
  input  logic             b_sgn,
  input  logic             sub,
  output logic [DST_W-1:0] sum
);
  logic [DST_W-1:0] a_ext;
  logic [DST_W-1:0] b_ext;
  logic             a_fill;
  logic             b_fill;

  always_comb begin
    a_fill = a_sgn & a_elem[SRC_W-1];
    b_fill = b_sgn & b_elem[SRC_W-1];
    a_ext  = {{SRC_W{a_fill}}, a_elem};
    b_ext  = {{SRC_W{b_fill}}, b_elem};
    if (sub) begin
      sum = a_ext - b_ext;
    end else begin
      sum = a_ext + b_ext;
    end
  end
endmodule

// File: rtl/wadd_width_unit.sv
module wadd_width_unit
  import simd_widen_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SRC_W = 8,
  localparam int DST_W = 2 * SRC_W,
  localparam int LANES = VEC_W / DST_W
) (
  input  lane_ctl_t        ctl,
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  output logic [VEC_W-1:0] res_vec
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SRC_W-1:0] a_pick;
    logic [SRC_W-1:0] b_pick;

    assign a_pick = ctl.a_odd ? a_vec[(2*i+1)*SRC_W +: SRC_W]
                              : a_vec[(2*i)*SRC_W +: SRC_W];
    assign b_pick = ctl.b_odd ? b_vec[(2*i+1)*SRC_W +: SRC_W]
                              : b_vec[(2*i)*SRC_W +: SRC_W];

    wadd_lane #(.SRC_W(SRC_W)) lane_i (
      .a_elem (a_pick),
      .b_elem (b_pick),
      .a_sgn  (ctl.a_sgn),
      .b_sgn  (ctl.b_sgn),
      .sub    (ctl.sub),
      .sum    (res_vec[i*DST_W +: DST_W])
    );
  end
endmodule

// File: rtl/simd_widen_addsub.sv
module simd_widen_addsub
  import simd_widen_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       pair_mode,
  input  logic             sub_op,
  input  logic [1:0]       sign_mode,
  input  logic [1:0]       src_width,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             res_valid,
  output logic [VEC_W-1:0] res_data
);
  lane_ctl_t        ctl;
  pair_e            pair;
  ext_e             ext;
  logic [VEC_W-1:0] unit_res [NUM_WIDTHS];
  logic [VEC_W-1:0] res_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_d;
  logic             vld_q;

  always_comb begin
    pair      = pair_e'(pair_mode);
    ext       = ext_e'(sign_mode);
    ctl.a_odd = (pair == PAIR_CROSS) || (pair == PAIR_ODD);
    ctl.b_odd = (pair == PAIR_ODD);
    ctl.a_sgn = (ext == EXT_SIGNED);
    ctl.b_sgn = (ext == EXT_SIGNED) || (ext == EXT_MIXED);
    ctl.sub   = sub_op;
  end

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    wadd_width_unit #(
      .VEC_W (VEC_W),
      .SRC_W (BASE_W << w)
    ) unit_i (
      .ctl     (ctl),
      .a_vec   (src_a),
      .b_vec   (src_b),
      .res_vec (unit_res[w])
    );
  end

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) begin
      res_d = unit_res[src_width];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign res_valid = vld_q;
  assign res_data  = res_q;
endmodule

// File: rtl/simd_widen_addsub_chk.sv
module simd_widen_addsub_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       pair_mode,
  input logic             sub_op,
  input logic [1:0]       sign_mode,
  input logic [1:0]       src_width,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] src_b,
  input logic             res_valid,
  input logic [VEC_W-1:0] res_data
);
  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  // R9
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data));

  // R4
  dword_signed_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_width == 2'd3 && pair_mode == 2'd1 && sign_mode == 2'd0 && !sub_op)
    |=> res_data == ($past({{64{src_a[63]}}, src_a[63:0]}) + $past({{64{src_b[63]}}, src_b[63:0]})));

  // R5
  dword_unsigned_odd_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_width == 2'd3 && pair_mode == 2'd2 && sign_mode == 2'd1 && sub_op)
    |=> res_data == ($past({64'd0, src_a[127:64]}) - $past({64'd0, src_b[127:64]})));
endmodule

bind simd_widen_addsub simd_widen_addsub_chk #(.VEC_W(VEC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .pair_mode (pair_mode),
  .sub_op    (sub_op),
  .sign_mode (sign_mode),
  .src_width (src_width),
  .src_a     (src_a),
  .src_b     (src_b),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/simd_widen_addsub_tb_top.sv
`timescale 1ns/100ps
module simd_widen_addsub_tb_top;
  localparam int VW    = 128;
  localparam int ENT_W = 24 + 7 + 3 * VW;
  localparam int N_ENT = 17;

  localparam logic [VW-1:0] AB = 128'h0F0E0D0C0B0A09080706050403020100;
  localparam logic [VW-1:0] BB = 128'h80808080808080808080808080808080;
  localparam logic [VW-1:0] AH = 128'h80007FFF80007FFF80007FFF80007FFF;
  localparam logic [VW-1:0] BH = 128'h00010001000100010001000100010001;
  localparam logic [VW-1:0] AW = 128'h00000005FFFFFFFF0000000100000000;
  localparam logic [VW-1:0] BW = 128'h00000000000000030000000000000002;
  localparam logic [VW-1:0] AD = 128'h00000000000012348000000000000000;
  localparam logic [VW-1:0] BD = 128'h00000000000000058000000000000000;

  // entry: {tag, pair, sub, sign, width, A, B, expected}
  localparam logic [ENT_W-1:0] TBL [N_ENT] = '{
    // R1 R4 cross signed byte add
    {"R1 ", 2'd0, 1'b0, 2'd0, 2'd0, AB, BB, 128'hFF8FFF8DFF8BFF89FF87FF85FF83FF81},
    // R5 cross unsigned byte add
    {"R5 ", 2'd0, 1'b0, 2'd1, 2'd0, AB, BB, 128'h008F008D008B00890087008500830081},
    // R6 cross signed byte subtract
    {"R6 ", 2'd0, 1'b1, 2'd0, 2'd0, AB, BB, 128'h008F008D008B00890087008500830081},
    // R2 even unsigned byte subtract
    {"R2 ", 2'd1, 1'b1, 2'd1, 2'd0, AB, BB, 128'hFF8EFF8CFF8AFF88FF86FF84FF82FF80},
    // R7 odd mixed byte add
    {"R7 ", 2'd2, 1'b0, 2'd2, 2'd0, AB, BB, 128'hFF8FFF8DFF8BFF89FF87FF85FF83FF81},
    // R7 even mixed byte subtract
    {"R7 ", 2'd1, 1'b1, 2'd2, 2'd0, AB, BB, 128'h008E008C008A00880086008400820080},
    // R3 even signed half add
    {"R3 ", 2'd1, 1'b0, 2'd0, 2'd1, AH, BH, 128'h00008000000080000000800000008000},
    // R4 odd signed half add
    {"R4 ", 2'd2, 1'b0, 2'd0, 2'd1, AH, BH, 128'hFFFF8001FFFF8001FFFF8001FFFF8001},
    // R5 odd unsigned half add
    {"R5 ", 2'd2, 1'b0, 2'd1, 2'd1, AH, BH, 128'h00008001000080010000800100008001},
    // R8 cross unsigned word subtract wraps
    {"R8 ", 2'd0, 1'b1, 2'd1, 2'd2, AW, BW, 128'h0000000000000002FFFFFFFFFFFFFFFF},
    // R4 even signed word add
    {"R4 ", 2'd1, 1'b0, 2'd0, 2'd2, AW, BW, 128'h00000000000000020000000000000002},
    // R5 even unsigned word add
    {"R5 ", 2'd1, 1'b0, 2'd1, 2'd2, AW, BW, 128'h00000001000000020000000000000002},
    // R12 reserved pair and sign codes
    {"R12", 2'd3, 1'b0, 2'd3, 2'd2, AW, BW, 128'h00000001000000020000000000000002},
    // R8 even signed dword add reaches -2^64
    {"R8 ", 2'd1, 1'b0, 2'd0, 2'd3, AD, BD, 128'hFFFFFFFFFFFFFFFF0000000000000000},
    // R3 even unsigned dword add reaches 2^64
    {"R3 ", 2'd1, 1'b0, 2'd1, 2'd3, AD, BD, 128'h00000000000000010000000000000000},
    // R6 cross unsigned dword subtract
    {"R6 ", 2'd0, 1'b1, 2'd1, 2'd3, AD, BD, 128'hFFFFFFFFFFFFFFFF8000000000001234},
    // R7 even mixed dword add
    {"R7 ", 2'd1, 1'b0, 2'd2, 2'd3, AD, BD, 128'h00000000000000000000000000000000}
  };

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    pair_mode;
  logic          sub_op;
  logic [1:0]    sign_mode;
  logic [1:0]    src_width;
  logic [VW-1:0] src_a;
  logic [VW-1:0] src_b;
  logic          res_valid;
  logic [VW-1:0] res_data;

  int checks;
  int errors;
  bit done;

  simd_widen_addsub #(.VEC_W(VW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pair_mode (pair_mode),
    .sub_op    (sub_op),
    .sign_mode (sign_mode),
    .src_width (src_width),
    .src_a     (src_a),
    .src_b     (src_b),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] pm, input logic so, input logic [1:0] sm,
                       input logic [1:0] sw, input logic [VW-1:0] a, input logic [VW-1:0] b);
    pair_mode = pm; sub_op = so; sign_mode = sm; src_width = sw; src_a = a; src_b = b;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] held;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0;
    drive(2'd0, 1'b0, 2'd0, 2'd0, '1, '1);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {127'd0, res_valid}, '0);
    check("R11", res_data, '0);
    rst_n = 1'b1;

    for (int e = 0; e < N_ENT; e++) begin
      @(negedge clk);
      drive(TBL[e][3*VW+6 -: 2], TBL[e][3*VW+4], TBL[e][3*VW+3 -: 2],
            TBL[e][3*VW+1 -: 2], TBL[e][3*VW-1 -: VW], TBL[e][2*VW-1 -: VW]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(string'(TBL[e][ENT_W-1 -: 24]), res_data, TBL[e][VW-1:0]);
      // R9 valid pulse accompanies the result
      check("R9", {127'd0, res_valid}, 128'd1);
    end

    // R9 valid low one cycle after strobe drops
    @(negedge clk);
    check("R9", {127'd0, res_valid}, '0);

    // R10 inputs change without strobe: result held
    held = res_data;
    drive(2'd1, 1'b0, 2'd1, 2'd3, AD, BD);
    repeat (2) @(negedge clk);
    check("R10", res_data, held);

    // R9 back to back operations
    drive(2'd1, 1'b0, 2'd1, 2'd3, AD, BD);
    in_valid = 1'b1;
    @(negedge clk);
    check("R9", res_data, 128'h00000000000000010000000000000000);
    drive(2'd0, 1'b1, 2'd1, 2'd2, AW, BW);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", res_data, 128'h0000000000000002FFFFFFFFFFFFFFFF);
    check("R9", {127'd0, res_valid}, 128'd1);

    // R2 odd signed word subtract: lane0 1-0, lane1 5-0
    drive(2'd2, 1'b1, 2'd0, 2'd2, AW, BW);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", res_data, 128'h00000000000000050000000000000001);

    // R11 reset during operation clears outputs
    drive(2'd1, 1'b0, 2'd1, 2'd3, AD, BD);
    in_valid = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    check("R11", {127'd0, res_valid}, '0);
    check("R11", res_data, '0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {127'd0, res_valid}, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule